// File: doc/BRIEF.md
# CMI Line Serializer

This block turns a parallel word of 2, 4 or 8 lanes into one serial line stream, lane 0 first. Everything runs from a single clock at the line symbol rate; each data bit occupies two symbol cycles, and the word clock of the parallel side is produced as a one-cycle strobe (`word_stb`) in the cycle during which `word_in` is captured. When `cmi_en` is high every bit is sent as a two-symbol Coded Mark Inversion pair. When it is low the bit value is simply held for both symbol cycles (NRZ pass-through at half the symbol rate).

A rising edge on `viol_req` is synchronised and turns exactly one later CMI mark into a deliberate code violation, for testing a far-end detector. A second serial output, `loop_out`, carries the same stream as `line_out` for a local loop path. It is forced to a fixed idle level while `loop_en` is low. Lane count and coding mode are taken from the inputs only at a word boundary, so software may change them at any time without splitting a word.

Top module: `cmi_serializer`

## Requirements
- R1: `width_sel` code 00 selects 2 lanes, 01 selects 4 lanes, 10 selects 8 lanes, and the reserved code 11 behaves as 8 lanes. `word_stb` is high for one cycle per word, and successive strobes are 2×lanes cycles apart. Lanes above the selected count are never transmitted.
- R2: Within a word, lane 0 is sent first, then lane 1 and so on. The first symbol of a word appears on `line_out` in the second cycle after the `word_stb` cycle, and symbols follow one per cycle with no gaps.
- R3: With CMI selected, a data 0 is sent as symbol 0 followed by symbol 1.
- R4: With CMI selected, a data 1 is sent as the pair 00 or the pair 11. The pair alternates on each successive 1, and the first 1 after reset is sent as 00.
- R5: With NRZ selected, each bit is driven at its own level for both of its symbol cycles, and the CMI alternation state is left unchanged.
- R6: A rising edge on `viol_req` makes the next CMI data 1 repeat the pair of the previous 1 (no alternation). The alternation then resumes from that repeated pair, so the 1 after it takes the opposite pair.
- R7: Holding `viol_req` high over several words inserts only one violation; ones after it alternate normally.
- R8: `cmi_en` and `width_sel` are sampled only in the `word_stb` cycle. A change in the middle of a word affects only the following word.
- R9: While `loop_en` was high at the previous clock edge, `loop_out` equals `line_out`. While it was low, `loop_out` is held at 0.
- R10: During reset `line_out` and `loop_out` are 0. In the first cycle after reset is released, `word_stb` is high so that the first word is taken at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmi_en | input | 1 | 1 = CMI coding, 0 = NRZ pass-through (sampled at word boundary) |
| width_sel | input | 2 | Lane count code: 00 = 2, 01 = 4, 10/11 = 8 (sampled at word boundary) |
| word_in | input | 8 | Parallel word, lane 0 in bit 0 |
| viol_req | input | 1 | Asynchronous request; each rising edge inserts one code violation |
| loop_en | input | 1 | Enables the loop serial output |
| word_stb | output | 1 | One-cycle word clock enable; `word_in` is captured in this cycle |
| line_out | output | 1 | Serial line symbol |
| loop_out | output | 1 | Loop copy of the line symbol, 0 when disabled |

## Verification
The bench drives words whose unused upper lanes carry ones. A mux that ignored the width code would leak those ones onto the line. It also uses the reserved width code, which a decoder missing the default case would turn into a short word and a wrong strobe spacing. Violation requests are raised during an all-zero word, so the repeated pair must land on the very next mark. A request held high across further words tests that an encoder re-triggering on level rather than edge would repeat marks again. Mode and width are changed in the middle of a playing word: a design that did not latch them at the boundary would re-code half a word. Stretches of NRZ between CMI words expose an alternation state that is wrongly advanced by NRZ ones.

// File: rtl/cmi_ser_pkg.sv
package cmi_ser_pkg;

   localparam int LANES_MAX = 8;

   typedef enum logic [1:0] {
      WSEL_2   = 2'b00,
      WSEL_4   = 2'b01,
      WSEL_8   = 2'b10,
      WSEL_RSV = 2'b11
   } wsel_e;

   // index of the last lane sent for a width code; the reserved code acts as 8 lanes
   function automatic logic [2:0] last_lane(input logic [1:0] code);
      case (code)
         WSEL_2:  return 3'd1;
         WSEL_4:  return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/cmi_word_timer.sv
module cmi_word_timer
   import cmi_ser_pkg::*;
#(
   parameter int IW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    width_sel,
   output logic          ph,
   output logic [IW-1:0] lane_idx,
   output logic          word_end
);

   logic          ph_q;
   logic [IW-1:0] idx_q;
   logic [1:0]    wsel_q;
   logic [IW-1:0] last_idx;

   assign last_idx = IW'(last_lane(wsel_q));
   assign word_end = ph_q && (idx_q == last_idx);
   assign ph       = ph_q;
   assign lane_idx = idx_q;

   // reset parks on the second half of the last lane so a word is taken at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= 1'b1;
         wsel_q <= WSEL_8;
         idx_q  <= IW'(last_lane(WSEL_8));
      end else begin
         ph_q <= ~ph_q;
         if (ph_q) begin
            if (word_end) begin
               idx_q  <= '0;
               wsel_q <= width_sel;
            end else begin
               idx_q <= idx_q + IW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cmi_lane_hold.sv
module cmi_lane_hold #(
   parameter int LANES = 8,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LANES-1:0] word_in,
   input  logic             cmi_en,
   input  logic [IW-1:0]    lane_idx,
   output logic             cur_bit,
   output logic             cmi_q
);

   logic [LANES-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         cmi_q  <= 1'b1;
      end else if (load) begin
         word_q <= word_in;
         cmi_q  <= cmi_en;
      end
   end

   assign cur_bit = word_q[lane_idx];

endmodule

// File: rtl/cmi_edge_sync.sv
module cmi_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic cur;
   logic held_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign cur = din;
      end else begin : g_chain
         logic [STAGES-1:0] ch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_q <= '0;
            else        ch_q <= (ch_q << 1) | STAGES'(din);
         end
         assign cur = ch_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_q <= 1'b0;
      else        held_q <= cur;
   end

   assign rise = cur & ~held_q;

endmodule

// File: rtl/cmi_symbol_enc.sv
module cmi_symbol_enc #(
   parameter bit LOOP_IDLE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ph,
   input  logic cur_bit,
   input  logic cmi_mode,
   input  logic viol_rise,
   input  logic loop_en,
   output logic line_out,
   output logic loop_out
);

   logic lvl_q;    // pair level for the next ordinary mark
   logic pend_q;   // violation waiting for a mark
   logic act_q;    // current mark is the violating one
   logic line_q;
   logic loop_q;
   logic mark;
   logic rep;
   logic use_lvl;
   logic sym;
   logic pend_d;

   assign mark    = cmi_mode & cur_bit;
   assign rep     = ph ? act_q : pend_q;
   assign use_lvl = rep ? ~lvl_q : lvl_q;
   assign pend_d  = viol_rise | (pend_q & ~(mark & ~ph));

   always_comb begin
      if (!cmi_mode)   sym = cur_bit;
      else if (cur_bit) sym = use_lvl;
      else             sym = ph;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         line_q <= 1'b0;
         loop_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         if (mark && !ph) act_q <= pend_q;
         if (mark && ph && !act_q) lvl_q <= ~lvl_q;
         line_q <= sym;
         loop_q <= loop_en ? sym : LOOP_IDLE;
      end
   end

   assign line_out = line_q;
   assign loop_out = loop_q;

endmodule

// File: rtl/cmi_serializer.sv
module cmi_serializer
   import cmi_ser_pkg::*;
#(
   parameter int LANES       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmi_en,
   input  logic [1:0]       width_sel,
   input  logic [LANES-1:0] word_in,
   input  logic             viol_req,
   input  logic             loop_en,
   output logic             word_stb,
   output logic             line_out,
   output logic             loop_out
);

   localparam int IW = $clog2(LANES);

   generate
      if (LANES != LANES_MAX) begin : g_bad_lanes
         $error("cmi_serializer: LANES must equal %0d to match the width codes", LANES_MAX);
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cmi_serializer: SYNC_STAGES must be 0 or 2..4");
      end
   endgenerate

   logic          ph;
   logic [IW-1:0] lane_idx;
   logic          word_end;
   logic          cur_bit;
   logic          cmi_q;
   logic          viol_rise;

   cmi_word_timer #(.IW(IW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .width_sel(width_sel),
      .ph       (ph),
      .lane_idx (lane_idx),
      .word_end (word_end)
   );

   cmi_lane_hold #(.LANES(LANES), .IW(IW)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (word_end),
      .word_in (word_in),
      .cmi_en  (cmi_en),
      .lane_idx(lane_idx),
      .cur_bit (cur_bit),
      .cmi_q   (cmi_q)
   );

   cmi_edge_sync #(.STAGES(SYNC_STAGES)) u_vsync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (viol_req),
      .rise (viol_rise)
   );

   cmi_symbol_enc #(.LOOP_IDLE(1'b0)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ph       (ph),
      .cur_bit  (cur_bit),
      .cmi_mode (cmi_q),
      .viol_rise(viol_rise),
      .loop_en  (loop_en),
      .line_out (line_out),
      .loop_out (loop_out)
   );

   assign word_stb = word_end;

endmodule

// File: rtl/cmi_serializer_chk.sv
module cmi_serializer_chk (
   input logic clk,
   input logic rst_n,
   input logic loop_en,
   input logic word_stb,
   input logic line_out,
   input logic loop_out,
   input logic ph,
   input logic cmi_q,
   input logic cur_bit
);

   logic [5:0] gap_q;
   logic       seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (word_stb) begin
         gap_q  <= 6'd1;
         seen_q <= 1'b1;
      end else if (gap_q != 6'h3f) begin
         gap_q <= gap_q + 6'd1;
      end
   end

   assert_word_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_stb && seen_q) |-> (gap_q == 6'd4 || gap_q == 6'd8 || gap_q == 6'd16));

   assert_stb_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      word_stb |=> !word_stb);

   assert_cmi_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ph && cmi_q && !cur_bit) |=> (line_out && !$past(line_out)));

   assert_cmi_mark_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ph && cmi_q && cur_bit) |=> $stable(line_out));

   assert_nrz_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph && !cmi_q) |=> $stable(line_out));

   assert_loop_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |=> (loop_out == line_out));

   assert_loop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |=> (loop_out == 1'b0));

endmodule

bind cmi_serializer cmi_serializer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .loop_en (loop_en),
   .word_stb(word_stb),
   .line_out(line_out),
   .loop_out(loop_out),
   .ph      (ph),
   .cmi_q   (cmi_q),
   .cur_bit (cur_bit)
);

// File: tb/sim_cmi_serializer.sv
module sim_cmi_serializer;

   localparam time CLK_PERIOD = 10ns;
   localparam int  N_ENT      = 16;
   localparam int  WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmi_en, viol_req, loop_en;
   logic [1:0] width_sel;
   logic [7:0] word_in;
   logic       word_stb, line_out, loop_out;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] e_data [N_ENT];
   logic [1:0] e_wsel [N_ENT];
   bit         e_cmi  [N_ENT];
   bit         e_viol [N_ENT];
   bit         e_loop [N_ENT];
   string      e_tag  [N_ENT];

   bit    exp_q [$];
   string tag_q [$];

   bit m_lvl = 1'b0;
   bit m_pend = 1'b0;
   int k = 0;
   bit adv = 1'b0;
   bit running = 1'b0;
   bit done = 1'b0;
   bit have_prev = 1'b0;
   int lag = -1;
   int gap = 0;
   int prev_len = 0;

   cmi_serializer u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmi_en   (cmi_en),
      .width_sel(width_sel),
      .word_in  (word_in),
      .viol_req (viol_req),
      .loop_en  (loop_en),
      .word_stb (word_stb),
      .line_out (line_out),
      .loop_out (loop_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R1: 00 -> 2 lanes, 01 -> 4, 10 and 11 -> 8
   function automatic int lanes_of(input logic [1:0] c);
      if (c == 2'b00) return 2;
      if (c == 2'b01) return 4;
      return 8;
   endfunction

   task automatic set_ent(input int i, input logic [1:0] w, input bit c, input logic [7:0] d,
                          input bit v, input bit l, input string t);
      e_wsel[i] = w; e_cmi[i] = c; e_data[i] = d; e_viol[i] = v; e_loop[i] = l; e_tag[i] = t;
   endtask

   task automatic apply(input int i);
      width_sel = e_wsel[i];
      cmi_en    = e_cmi[i];
      word_in   = e_data[i];
      viol_req  = e_viol[i];
      loop_en   = e_loop[i];
   endtask

   task automatic push_sym(input bit s, input string t);
      exp_q.push_back(s);
      tag_q.push_back(t);
   endtask

   // driver: expected symbols of the word captured in this strobe cycle, lane 0 first (R2)
   task automatic push_word(input int idx);
      int n;
      n = lanes_of(width_sel);
      if (e_viol[idx] && (idx == 0 || !e_viol[idx-1])) m_pend = 1'b1;
      for (int i = 0; i < n; i++) begin
         bit b;
         bit u;
         string t;
         b = word_in[i];
         if (cmi_en) begin
            if (b) begin
               u = m_pend ? ~m_lvl : m_lvl;
               t = m_pend ? "R6" : (e_viol[idx] ? "R7" : "R4");
               push_sym(u, {e_tag[idx], "/", t});
               push_sym(u, {e_tag[idx], "/", t});
               if (m_pend) m_pend = 1'b0;
               else        m_lvl = ~m_lvl;
            end else begin
               push_sym(1'b0, {e_tag[idx], "/R3"});
               push_sym(1'b1, {e_tag[idx], "/R3"});
            end
         end else begin
            push_sym(b, {e_tag[idx], "/R5"});
            push_sym(b, {e_tag[idx], "/R5"});
         end
      end
   endtask

   // monitor first, then driver, in one process at the falling edge
   always @(negedge clk) begin
      bit    e;
      string t;
      if (running) begin
         if (lag > 0) lag--;
         if (lag == 0 && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(line_out === e, t, int'(line_out), int'(e));
            check(loop_out === (loop_en ? e : 1'b0), {t, "/R9 loop"}, int'(loop_out),
                  int'(loop_en ? e : 1'b0));
         end
         gap++;
         if (word_stb && k < N_ENT) begin
            if (have_prev) check(gap == prev_len, "R1 strobe spacing", gap, prev_len);
            gap = 0;
            have_prev = 1'b1;
            prev_len = 2 * lanes_of(width_sel);
            push_word(k);
            if (lag < 0) lag = 2;   // R2: first symbol two cycles after strobe
            adv = 1'b1;
         end else if (adv) begin
            adv = 1'b0;
            k++;
            if (k < N_ENT) apply(k);   // R8: changes land while the previous word plays
            else           done = 1'b1;
         end
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      set_ent(0,  2'b00, 1'b1, 8'hF2, 1'b0, 1'b1, "R1");  // upper lanes set, must not be sent
      set_ent(1,  2'b00, 1'b1, 8'h03, 1'b0, 1'b1, "R2");
      set_ent(2,  2'b01, 1'b1, 8'hA5, 1'b0, 1'b1, "R1");
      set_ent(3,  2'b10, 1'b1, 8'h00, 1'b0, 1'b1, "R2");
      set_ent(4,  2'b10, 1'b1, 8'hFF, 1'b0, 1'b1, "R2");
      set_ent(5,  2'b01, 1'b0, 8'h36, 1'b0, 1'b0, "R8");  // NRZ, loop off
      set_ent(6,  2'b10, 1'b0, 8'hC9, 1'b0, 1'b0, "R8");
      set_ent(7,  2'b01, 1'b1, 8'h0B, 1'b0, 1'b0, "R8");
      set_ent(8,  2'b11, 1'b1, 8'h5A, 1'b0, 1'b1, "R1");  // reserved code acts as 8 lanes
      set_ent(9,  2'b10, 1'b1, 8'h00, 1'b0, 1'b1, "R2");
      set_ent(10, 2'b01, 1'b1, 8'h0D, 1'b1, 1'b1, "R6");  // violation rise
      set_ent(11, 2'b01, 1'b1, 8'hF0, 1'b1, 1'b1, "R7");  // request held
      set_ent(12, 2'b10, 1'b1, 8'hE7, 1'b1, 1'b1, "R7");
      set_ent(13, 2'b01, 1'b1, 8'h00, 1'b0, 1'b0, "R2");
      set_ent(14, 2'b01, 1'b1, 8'h07, 1'b1, 1'b1, "R6");  // second rise
      set_ent(15, 2'b00, 1'b1, 8'h02, 1'b0, 1'b1, "R4");
      apply(0);

      repeat (3) @(negedge clk);
      check(line_out === 1'b0, "R10 line in reset", int'(line_out), 0);
      check(loop_out === 1'b0, "R10 loop in reset", int'(loop_out), 0);

      @(posedge clk);
      #(CLK_PERIOD/4);
      rst_n   = 1'b1;
      running = 1'b1;
      @(negedge clk);
      check(word_stb === 1'b1, "R10 strobe after reset", int'(word_stb), 1);

      wait (done);
      repeat (40) @(negedge clk);
      check(exp_q.size() == 0, "R2 stream drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule